// File: doc/BRIEF.md
# Write-Protected Multi-Bank GPIO Register Core

This block is the register core of a general-purpose I/O controller. It serves a configurable number of banks (one to eight) of 32 pins each. It drives three pin vectors: an output value, an output enable and an input sampled from the pads. Software reaches it over a simple word-addressed register bus with separate write and read strobes. Reads return data one cycle after the read strobe.

Pin outputs never take a written value directly. Software sets bits through an output-set register and clears them through an output-clear register, one of each per bank. This lets several agents change different pins without a read-modify-write race. Each pin also has its own control word. Bit 0 of that word picks the direction. The remaining configuration bits (edge select, debounce fields) are stored and read back for the interrupt and debounce logic that sits beside this core.

Every bank carries a write protection. After reset all banks are locked, and a locked bank drops every write to its set, clear and pin-control registers. To open a bank, software writes a magic password to a global register. The very next bus access must then be a write of the unlock code to that bank's lock register. Writing the lock code through the same two-step sequence closes the bank again.

Top module: `gpio_lock_core`

## Requirements
- R1: After reset every pin is an input (pin_oe all 0), pin_out is all 0, every bank reads as locked, and control bit 0 of every pin reads 1.
- R2: A write of 0x00A5A501 to byte offset 0x520, followed directly by a write to 0x500+4*bank, changes that bank's lock state and no other. The data 0x00000000 unlocks the bank and 0xFFFFFFFF locks it.
- R3: A lock-register write is ignored unless the bus access just before it was a correct password write. Idle cycles between the two writes do not cancel the password. Any bus access in between does: a read, a wrong password, or a write anywhere else.
- R4: After a correct password, a lock-register write whose data is neither 0x00000000 nor 0xFFFFFFFF leaves the lock state unchanged and still uses up the password.
- R5: A write to 0x040+4*bank on an unlocked bank sets each pin_out bit of that bank whose data bit is 1. Bits written as 0 keep their value.
- R6: A write to 0x060+4*bank on an unlocked bank clears each pin_out bit of that bank whose data bit is 1. Bits written as 0 keep their value.
- R7: Writes to the set, clear or pin-control registers of a locked bank change neither pin_out, pin_oe nor the stored control word.
- R8: A read of 0x000+4*bank returns that bank's 32 output bits, with pin 32*bank+i at data bit i.
- R9: A read of 0x020+4*bank returns the bank's pin_in bits after a two-flop synchronizer. A change on pin_in at a clock edge first appears in a read whose strobe is sampled three edges later.
- R10: The control word of pin p sits at 0x100+4*p. On write, bit 0 (1 = input, 0 = output) sets pin_oe[p] to its inverse, and bits 8..1 are stored. On read, bits 8..0 come back and bits 31..9 read 0.
- R11: Read data appears on bus_rdata in the cycle after the read strobe. Reads of unmapped, out-of-range or misaligned addresses (address bits 1..0 not 00) return 0, and writes to them change nothing.
- R12: A read of a lock register 0x500+4*bank returns 1 in bit 0 while the bank is locked and 0 while it is open. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (12) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| pin_in | input | 32*NUM_BANKS | Pad input values, asynchronous |
| pin_out | output | 32*NUM_BANKS | Pin output values |
| pin_oe | output | 32*NUM_BANKS | Pin output enables, 1 = driving |

## Verification
The hardest case to reach from the ports is the lock register sequence under interference. A random access stream seldom places a password write directly before a lock write to the right bank with the right code. The bench therefore mixes password writes and lock writes heavily into its random traffic, alongside set, clear, control and read accesses, so the armed password often gets used, wasted or cancelled. Directed sequences cover the exact cases on their own: a read or a wrong password between the two writes, a bad lock code, and idle cycles that must not cancel the password.

// File: rtl/gpio_lock_pkg.sv
package gpio_lock_pkg;

  localparam int BANK_PINS = 32;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_OUTSTAT,
    RG_INSTAT,
    RG_SET,
    RG_CLR,
    RG_CTRL,
    RG_LOCK,
    RG_PWD
  } region_e;

endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_lock_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 12,
  parameter int BANK_W    = 3,
  parameter int PIN_W     = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [BANK_W-1:0] bank,
  output logic [PIN_W-1:0]  pin
);

  localparam int NPINS    = NUM_BANKS * BANK_PINS;
  localparam int OFF_CTRL = 32'h100;
  localparam int OFF_LOCK = 32'h500;
  localparam int OFF_PWD  = 32'h520;

  int unsigned a_u;
  int unsigned grp;
  int unsigned bsel;
  int unsigned pidx;
  int unsigned lidx;

  always_comb begin
    region = RG_NONE;
    bank   = '0;
    pin    = '0;
    a_u    = 32'(addr);
    grp    = a_u >> 5;
    bsel   = (a_u >> 2) & 32'd7;
    pidx   = (a_u - OFF_CTRL) >> 2;
    lidx   = (a_u - OFF_LOCK) >> 2;
    if (addr[1:0] == 2'b00) begin
      if (a_u < OFF_CTRL) begin
        if (bsel < NUM_BANKS) begin
          bank = bsel[BANK_W-1:0];
          case (grp)
            32'd0:   region = RG_OUTSTAT;
            32'd1:   region = RG_INSTAT;
            32'd2:   region = RG_SET;
            32'd3:   region = RG_CLR;
            default: region = RG_NONE;
          endcase
        end
      end else if (a_u < OFF_CTRL + 4 * NPINS) begin
        region = RG_CTRL;
        pin    = pidx[PIN_W-1:0];
        bank   = pidx[PIN_W-1:5];
      end else if (a_u >= OFF_LOCK && a_u < OFF_LOCK + 4 * NUM_BANKS) begin
        region = RG_LOCK;
        bank   = lidx[BANK_W-1:0];
      end else if (a_u == OFF_PWD) begin
        region = RG_PWD;
      end
    end
  end

endmodule

// File: rtl/gpio_lock_guard.sv
module gpio_lock_guard
  import gpio_lock_pkg::*;
#(
  parameter int          NUM_BANKS   = 8,
  parameter int          BANK_W      = 3,
  parameter logic [31:0] PASSWORD    = 32'h00A5A501,
  parameter logic [31:0] LOCK_CODE   = 32'hFFFFFFFF,
  parameter logic [31:0] UNLOCK_CODE = 32'h00000000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acc,
  input  logic                 wr,
  input  region_e              region,
  input  logic [BANK_W-1:0]    bank,
  input  logic [31:0]          wdata,
  output logic [NUM_BANKS-1:0] locked_q,
  output logic                 armed_q
);

  logic pwd_hit;
  logic lock_wr;

  assign pwd_hit = wr && (region == RG_PWD) && (wdata == PASSWORD);
  assign lock_wr = wr && (region == RG_LOCK) && armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= '1;
      armed_q  <= 1'b0;
    end else if (acc) begin
      armed_q <= pwd_hit;
      if (lock_wr) begin
        if (wdata == UNLOCK_CODE) begin
          locked_q[bank] <= 1'b0;
        end else if (wdata == LOCK_CODE) begin
          locked_q[bank] <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 256,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) begin
        stage_q[s] <= '0;
      end
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) begin
        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_array.sv
module gpio_pin_array
  import gpio_lock_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = 3,
  parameter int PIN_W     = 8,
  parameter int CFG_W     = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_set,
  input  logic                           wr_clr,
  input  logic                           wr_ctrl,
  input  logic                           rd_ctrl,
  input  logic [BANK_W-1:0]              bank,
  input  logic [PIN_W-1:0]               pin,
  input  logic [31:0]                    wdata,
  output logic [NUM_BANKS*BANK_PINS-1:0] out_q,
  output logic [NUM_BANKS*BANK_PINS-1:0] oe_q,
  output logic [CFG_W-1:0]               cfg_rd_q
);

  localparam int NPINS = NUM_BANKS * BANK_PINS;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [BANK_PINS-1:0] val_q;
    logic                 hit;

    assign hit = (bank == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (rst) begin
        val_q <= '0;
      end else if (wr_set && hit) begin
        val_q <= val_q | wdata;
      end else if (wr_clr && hit) begin
        val_q <= val_q & ~wdata;
      end
    end

    assign out_q[b*BANK_PINS +: BANK_PINS] = val_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q <= '0;
    end else if (wr_ctrl) begin
      oe_q[pin] <= ~wdata[0];
    end
  end

  logic [CFG_W-1:0] cfg_mem [NPINS];

  always_ff @(posedge clk) begin
    if (wr_ctrl) begin
      cfg_mem[pin] <= wdata[CFG_W:1];
    end
    if (rd_ctrl) begin
      cfg_rd_q <= cfg_mem[pin];
    end
  end

endmodule

// File: rtl/gpio_lock_core.sv
module gpio_lock_core
  import gpio_lock_pkg::*;
#(
  parameter int          NUM_BANKS   = 8,
  parameter int          ADDR_W      = 12,
  parameter int          CFG_W       = 8,
  parameter logic [31:0] PASSWORD    = 32'h00A5A501,
  parameter logic [31:0] LOCK_CODE   = 32'hFFFFFFFF,
  parameter logic [31:0] UNLOCK_CODE = 32'h00000000
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           bus_wr,
  input  logic                           bus_rd,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [31:0]                    bus_wdata,
  output logic [31:0]                    bus_rdata,
  input  logic [NUM_BANKS*BANK_PINS-1:0] pin_in,
  output logic [NUM_BANKS*BANK_PINS-1:0] pin_out,
  output logic [NUM_BANKS*BANK_PINS-1:0] pin_oe
);

  localparam int NPINS  = NUM_BANKS * BANK_PINS;
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int PIN_W  = BANK_W + $clog2(BANK_PINS);
  localparam int PAD_W  = 32 - 1 - CFG_W;

  region_e              region;
  logic [BANK_W-1:0]    bank;
  logic [PIN_W-1:0]     pin;
  logic [NUM_BANKS-1:0] locked_q;
  logic                 armed_q;
  logic [NPINS-1:0]     in_sync;
  logic [NPINS-1:0]     out_q;
  logic [NPINS-1:0]     oe_q;
  logic [CFG_W-1:0]     cfg_rd_q;
  logic                 bank_open;
  logic                 wr_set;
  logic                 wr_clr;
  logic                 wr_ctrl;
  logic                 rd_ctrl;

  gpio_reg_decode #(
    .NUM_BANKS(NUM_BANKS),
    .ADDR_W   (ADDR_W),
    .BANK_W   (BANK_W),
    .PIN_W    (PIN_W)
  ) u_decode (
    .addr  (bus_addr),
    .region(region),
    .bank  (bank),
    .pin   (pin)
  );

  gpio_lock_guard #(
    .NUM_BANKS  (NUM_BANKS),
    .BANK_W     (BANK_W),
    .PASSWORD   (PASSWORD),
    .LOCK_CODE  (LOCK_CODE),
    .UNLOCK_CODE(UNLOCK_CODE)
  ) u_guard (
    .clk     (clk),
    .rst     (rst),
    .acc     (bus_wr | bus_rd),
    .wr      (bus_wr),
    .region  (region),
    .bank    (bank),
    .wdata   (bus_wdata),
    .locked_q(locked_q),
    .armed_q (armed_q)
  );

  gpio_in_sync #(
    .WIDTH (NPINS),
    .STAGES(2)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .din (pin_in),
    .dout(in_sync)
  );

  assign bank_open = ~locked_q[bank];
  assign wr_set    = bus_wr && (region == RG_SET)  && bank_open;
  assign wr_clr    = bus_wr && (region == RG_CLR)  && bank_open;
  assign wr_ctrl   = bus_wr && (region == RG_CTRL) && bank_open;
  assign rd_ctrl   = bus_rd && (region == RG_CTRL);

  gpio_pin_array #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W),
    .PIN_W    (PIN_W),
    .CFG_W    (CFG_W)
  ) u_pins (
    .clk     (clk),
    .rst     (rst),
    .wr_set  (wr_set),
    .wr_clr  (wr_clr),
    .wr_ctrl (wr_ctrl),
    .rd_ctrl (rd_ctrl),
    .bank    (bank),
    .pin     (pin),
    .wdata   (bus_wdata),
    .out_q   (out_q),
    .oe_q    (oe_q),
    .cfg_rd_q(cfg_rd_q)
  );

  logic [31:0] rd_hold_q;
  logic        rd_ctrl_q;
  logic        rd_dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_hold_q <= '0;
      rd_ctrl_q <= 1'b0;
      rd_dir_q  <= 1'b0;
    end else if (bus_rd) begin
      rd_ctrl_q <= (region == RG_CTRL);
      rd_dir_q  <= ~oe_q[pin];
      case (region)
        RG_OUTSTAT: rd_hold_q <= out_q[BANK_PINS*int'(bank) +: BANK_PINS];
        RG_INSTAT:  rd_hold_q <= in_sync[BANK_PINS*int'(bank) +: BANK_PINS];
        RG_LOCK:    rd_hold_q <= {31'd0, locked_q[bank]};
        default:    rd_hold_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rd_ctrl_q ? {{PAD_W{1'b0}}, cfg_rd_q, rd_dir_q} : rd_hold_q;
  assign pin_out   = out_q;
  assign pin_oe    = oe_q;

endmodule

// File: rtl/gpio_lock_core_chk.sv
module gpio_lock_core_chk #(
  parameter int NUM_BANKS = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      bus_wr,
  input logic                      bus_rd,
  input logic [NUM_BANKS*32-1:0]   pin_out,
  input logic [NUM_BANKS*32-1:0]   pin_oe,
  input logic [NUM_BANKS-1:0]      locked,
  input logic                      armed
);

  AST_RESET_CLEAN: assert property (@(posedge clk)
    $past(rst) |-> (pin_out == '0 && pin_oe == '0 && (&locked))); // R1

  AST_LOCK_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    (locked != $past(locked)) |-> ($past(armed) && $past(bus_wr))); // R3

  AST_ONE_BANK_MOVES: assert property (@(posedge clk) disable iff (rst)
    $onehot0(locked ^ $past(locked))); // R2

  AST_READ_DISARMS: assert property (@(posedge clk) disable iff (rst)
    ($past(armed) && $past(bus_rd) && !$past(bus_wr)) |-> !armed); // R3

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
    AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (rst)
      $past(locked[b]) |-> ($stable(pin_out[b*32 +: 32]) && $stable(pin_oe[b*32 +: 32]))); // R7
  end

endmodule

bind gpio_lock_core gpio_lock_core_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .bus_wr (bus_wr),
  .bus_rd (bus_rd),
  .pin_out(pin_out),
  .pin_oe (pin_oe),
  .locked (locked_q),
  .armed  (armed_q)
);

// File: tb/gpio_lock_core_tb.sv
`timescale 1ns/1ps
module gpio_lock_core_tb;

  localparam int          NB   = 8;
  localparam int          NP   = NB * 32;
  localparam logic [31:0] PASS = 32'h00A5A501;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;

  always #2 clk = ~clk;

  gpio_lock_core u_dut (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pin_in   (pin_in),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [31:0] m_out [NB];
  bit          m_lock [NB];
  bit          m_dir [NP];
  logic [7:0]  m_cfg [NP];
  bit          m_cfg_known [NP];
  bit          m_armed;

  function automatic void mdl_reset();
    for (int b = 0; b < NB; b++) begin
      m_out[b]  = '0;
      m_lock[b] = 1'b1;
    end
    for (int p = 0; p < NP; p++) begin
      m_dir[p]       = 1'b1;
      m_cfg[p]       = '0;
      m_cfg_known[p] = 1'b0;
    end
    m_armed = 1'b0;
  endfunction

  function automatic void mdl_access(bit w, int unsigned a, logic [31:0] d);
    bit nxt = 1'b0;
    int unsigned b;
    int unsigned p;
    if (w && (a % 4) == 0) begin
      if (a == 32'h520 && d == PASS) nxt = 1'b1;
      if (a >= 32'h500 && a < 32'h500 + 4*NB && m_armed) begin
        b = (a - 32'h500) / 4;
        if (d == 32'h0) m_lock[b] = 1'b0;
        else if (d == 32'hFFFFFFFF) m_lock[b] = 1'b1;
      end
      if (a >= 32'h40 && a < 32'h40 + 4*NB) begin
        b = (a - 32'h40) / 4;
        if (!m_lock[b]) m_out[b] = m_out[b] | d;
      end
      if (a >= 32'h60 && a < 32'h60 + 4*NB) begin
        b = (a - 32'h60) / 4;
        if (!m_lock[b]) m_out[b] = m_out[b] & ~d;
      end
      if (a >= 32'h100 && a < 32'h100 + 4*NP) begin
        p = (a - 32'h100) / 4;
        if (!m_lock[p/32]) begin
          m_dir[p]       = d[0];
          m_cfg[p]       = d[8:1];
          m_cfg_known[p] = 1'b1;
        end
      end
    end
    m_armed = nxt;
  endfunction

  function automatic logic [31:0] mdl_read(int unsigned a, output logic [31:0] msk);
    int unsigned b;
    int unsigned p;
    msk = 32'hFFFFFFFF;
    if ((a % 4) != 0) return 32'h0;
    if (a < 32'h20 + 0 && a < 4*NB) return m_out[a/4];
    if (a >= 32'h20 && a < 32'h20 + 4*NB) begin
      b = (a - 32'h20) / 4;
      return pin_in[b*32 +: 32];
    end
    if (a >= 32'h100 && a < 32'h100 + 4*NP) begin
      p = (a - 32'h100) / 4;
      if (!m_cfg_known[p]) msk = 32'hFFFFFE01;
      return {23'd0, m_cfg[p], m_dir[p]};
    end
    if (a >= 32'h500 && a < 32'h500 + 4*NB) begin
      b = (a - 32'h500) / 4;
      return {31'd0, m_lock[b]};
    end
    return 32'h0;
  endfunction

  task automatic chk32(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chkv(string tag, logic [NP-1:0] got, logic [NP-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(int unsigned a, logic [31:0] d);
    bus_wr    = 1'b1;
    bus_addr  = a[11:0];
    bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    mdl_access(1'b1, a, d);
  endtask

  task automatic rd_chk(string tag, int unsigned a);
    logic [31:0] e;
    logic [31:0] m;
    e = mdl_read(a, m);
    bus_rd   = 1'b1;
    bus_addr = a[11:0];
    @(negedge clk);
    bus_rd = 1'b0;
    chk32(tag, bus_rdata & m, e & m);
    mdl_access(1'b0, a, 32'h0);
  endtask

  task automatic rd_raw(int unsigned a, output logic [31:0] d);
    bus_rd   = 1'b1;
    bus_addr = a[11:0];
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    mdl_access(1'b0, a, 32'h0);
  endtask

  task automatic pins_chk(string tag);
    logic [NP-1:0] eo;
    logic [NP-1:0] ee;
    for (int b = 0; b < NB; b++) eo[b*32 +: 32] = m_out[b];
    for (int p = 0; p < NP; p++) ee[p] = ~m_dir[p];
    chkv({tag, " pin_out"}, pin_out, eo);
    chkv({tag, " pin_oe"}, pin_oe, ee);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_bank(int b, logic [31:0] code);
    wr(32'h520, PASS);
    wr(32'h500 + 4*b, code);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [NP-1:0] old_in;
    logic [NP-1:0] new_in;
    int op;
    void'($urandom(32'd20240611));
    mdl_reset();
    idle(5);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    pins_chk("R1");
    rd_chk("R1 lock bank0", 32'h500);
    rd_chk("R1 lock bank7", 32'h51C);
    rd_chk("R1 ctrl pin5 dir", 32'h114);

    // R7 set to locked bank dropped
    wr(32'h040, 32'hFFFFFFFF);
    pins_chk("R7 set locked");
    rd_chk("R8 outstat bank0", 32'h000);

    // R3 lock write without password
    wr(32'h500, 32'h0);
    rd_chk("R3 no pwd", 32'h500);
    // R3 read between password and lock write
    wr(32'h520, PASS);
    rd_chk("R11 unmapped read", 32'h600);
    wr(32'h500, 32'h0);
    rd_chk("R3 read between", 32'h500);
    // R3 wrong password after right one
    wr(32'h520, PASS);
    wr(32'h520, 32'h00A5A500);
    wr(32'h500, 32'h0);
    rd_chk("R3 wrong pwd", 32'h500);
    // R4 bad code then good code without new password
    open_bank(0, 32'h12345678);
    rd_chk("R4 bad code", 32'h500);
    wr(32'h500, 32'h0);
    rd_chk("R4 password used up", 32'h500);

    // R2 unlock bank 2 only
    open_bank(2, 32'h0);
    rd_chk("R2 bank2 open", 32'h508);
    rd_chk("R12 bank3 still locked", 32'h50C);
    chk32("R12 bank2 lock read", 32'(m_lock[2]), 32'h0);

    // R5 / R6 set and clear
    wr(32'h048, 32'hF0F00001);
    pins_chk("R5 set");
    wr(32'h048, 32'h00000010);
    pins_chk("R5 set or");
    rd_chk("R8 outstat bank2", 32'h008);
    wr(32'h068, 32'hF0000000);
    pins_chk("R6 clear");
    wr(32'h068, 32'h0);
    rd_chk("R6 clear zero", 32'h008);
    chk32("R6 value", m_out[2], 32'h00F00011);

    // R10 control words on bank 2 pin 64
    wr(32'h100 + 4*64, 32'h000001FE);
    pins_chk("R10 output dir");
    rd_chk("R10 readback", 32'h100 + 4*64);
    wr(32'h100 + 4*64, 32'hFFFFFF55);
    pins_chk("R10 input dir");
    rd_chk("R10 upper zero", 32'h100 + 4*64);
    chk32("R10 stored", {23'd0, m_cfg[64], m_dir[64]}, 32'h00000155);
    wr(32'h100 + 4*65, 32'h0);
    pins_chk("R10 pin65 output");

    // R7 control to locked bank 3
    wr(32'h100 + 4*96, 32'h0);
    pins_chk("R7 ctrl locked");
    wr(32'h06C, 32'hFFFFFFFF);
    pins_chk("R7 clear locked");

    // R3 idle cycles keep password; relock bank 2
    wr(32'h520, PASS);
    idle(3);
    wr(32'h508, 32'hFFFFFFFF);
    rd_chk("R3 idle keeps pwd", 32'h508);
    wr(32'h048, 32'hFFFFFFFF);
    pins_chk("R7 relocked set");

    // R11 misaligned and unmapped
    open_bank(1, 32'h0);
    wr(32'h045, 32'hFFFFFFFF);
    pins_chk("R11 misaligned write");
    rd_chk("R11 misaligned read", 32'h004 + 1);
    rd_chk("R11 pwd reads zero", 32'h520);
    wr(32'h0A4, 32'hFFFFFFFF);
    pins_chk("R11 unmapped write");

    // R9 synchronizer latency
    old_in = pin_in;
    new_in = old_in;
    new_in[32 +: 32] = 32'hCAFE1234;
    pin_in = new_in;
    rd_raw(32'h024, d);
    chk32("R9 edge1 old", d, old_in[32 +: 32]);
    rd_raw(32'h024, d);
    chk32("R9 edge2 old", d, old_in[32 +: 32]);
    rd_raw(32'h024, d);
    chk32("R9 edge3 new", d, 32'hCAFE1234);

    // Random mix
    for (int it = 0; it < 3000; it++) begin
      op = $urandom_range(0, 99);
      if (op < 20) begin
        wr(32'h520, ($urandom_range(0, 7) == 0) ? $urandom : PASS);
      end else if (op < 40) begin
        int sel;
        sel = $urandom_range(0, 2);
        wr(32'h500 + 4*$urandom_range(0, NB-1),
           (sel == 0) ? 32'h0 : (sel == 1) ? 32'hFFFFFFFF : $urandom);
        rd_chk("R2 random lock", 32'h500 + 4*$urandom_range(0, NB-1));
      end else if (op < 52) begin
        wr(32'h040 + 4*$urandom_range(0, NB-1), $urandom);
        pins_chk("R5 random");
      end else if (op < 64) begin
        wr(32'h060 + 4*$urandom_range(0, NB-1), $urandom);
        pins_chk("R6 random");
      end else if (op < 76) begin
        wr(32'h100 + 4*$urandom_range(0, NP-1), $urandom);
        pins_chk("R10 random");
      end else if (op < 80) begin
        for (int w = 0; w < NB; w++) pin_in[w*32 +: 32] = $urandom;
        idle(2);
      end else begin
        int r;
        r = $urandom_range(0, 4);
        case (r)
          0: rd_chk("R8 random", 32'h000 + 4*$urandom_range(0, NB-1));
          1: rd_chk("R9 random", 32'h020 + 4*$urandom_range(0, NB-1));
          2: rd_chk("R10 random read", 32'h100 + 4*$urandom_range(0, NP-1));
          3: rd_chk("R12 random", 32'h500 + 4*$urandom_range(0, NB-1));
          default: rd_chk("R11 random", 32'h600 + 4*$urandom_range(0, 100));
        endcase
      end
    end
    pins_chk("R7 final");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule